// File: doc/BRIEF.md
# Parallel Printer Port Host Controller

This block is the host end of a byte-wide, strobe-and-acknowledge printer link. A CPU reaches it through a four-location register window: one location takes the byte to print, one holds the line-control bits, one reports status, and one sets a transfer timeout. When the CPU writes a byte, the block places it on eight output lines. It waits until the printer is not busy, then pulls the active-low strobe for a minimum width that is computed from the clock frequency, and waits for the printer's active-low acknowledge pulse.

The block also drives three control lines to the printer: line feed, printer choose and printer reset. The reset pulse is long and has its own timer. The printer's busy, out-of-paper, online and fault inputs pass through two-flop synchronizers before use. A timeout guards against a printer that never answers. A byte written while a transfer is still running is dropped and raises a flag.

Top module: `lpt_host_ctrl`

## Requirements
- R1: After reset, pr_stb_n, pr_feed_n, pr_choose_n and pr_reset_n are high, pr_data is 0, and the status and control registers read 0 while the printer inputs are idle (busy 0, no-paper 0, online 0, fault_n 1).
- R2: Register map: address 0 holds data, 1 holds control, 2 holds status and 3 holds the timeout limit. A byte accepted at address 0 appears on pr_data with bit i on line i, so bit 0 is the LSB. It is stable from at least one clock before pr_stb_n falls until at least one clock after pr_stb_n rises.
- R3: pr_stb_n stays low for exactly STB_CYC = ceil(CLK_KHZ*STB_NS/1e6) clocks, which is 5 in the bench configuration.
- R4: A strobe does not start while the synchronized busy input is high or while the reset pulse is active. The transfer waits and then proceeds once both are clear.
- R5: A falling edge of the synchronized acknowledge input, seen after the strobe has ended, completes the transfer. It sets the done bit (status bit 4) and clears the active bit (status bit 7).
- R6: With a timeout limit L other than 0, a transfer still open about L*2^TICK_LOG2 clocks after it was accepted (64 clocks for L=4 in the bench) ends. It sets the timeout bit (status bit 5) without setting done and returns to idle. L=0 disables the timeout.
- R7: A data write while a transfer is active is ignored: pr_data keeps the old byte. It sets the overrun bit (status bit 6).
- R8: Writing control with bit 2 set drives pr_reset_n low for exactly INIT_CYC = CLK_KHZ*INIT_US/1000+1 clocks, which is 501 in the bench configuration. While the pulse runs, control bit 2 reads 1, and a further request is ignored without stretching the pulse.
- R9: pr_feed_n is the inverse of control bit 0 and pr_choose_n is the inverse of control bit 1. Control reads back these two bits in the same positions.
- R10: Status bit 0 is synchronized busy, bit 1 no-paper, bit 2 online and bit 3 fault (the inverse of pr_fault_n). Writing 1 to status bits 4 to 6 clears the matching flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected address |
| pr_data | output | 8 | Byte to the printer |
| pr_stb_n | output | 1 | Active-low data strobe |
| pr_feed_n | output | 1 | Active-low line feed |
| pr_reset_n | output | 1 | Active-low printer reset pulse |
| pr_choose_n | output | 1 | Active-low printer choose |
| pr_busy | input | 1 | Printer busy, offline or in error |
| pr_ack_n | input | 1 | Active-low acknowledge pulse |
| pr_nopaper | input | 1 | High when out of paper |
| pr_online | input | 1 | High when the printer is selected |
| pr_fault_n | input | 1 | Active-low fault |

## Verification
If the handshake sequencer enters a wrong state, the fault shows on pr_stb_n within a few clocks. The strobe can come too early, be too narrow or too wide, or go missing, and a byte can change under an active strobe. The status bits then show done, timeout or active with the wrong values when the transfer ends. A fault in the reset-pulse timer shows as a pr_reset_n width different from the computed count, or as a second request that stretches the pulse. Synchronizer or status-mapping faults appear two to three clocks after an input changes, as a wrong bit in the status read.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  typedef enum logic [2:0] {
    X_IDLE,
    X_WAITRDY,
    X_SETUP,
    X_STROBE,
    X_HOLD,
    X_WAITACK
  } xfer_st_e;

  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_TLIM = 2'd3;

  localparam int S_BUSY   = 0;
  localparam int S_NOPAP  = 1;
  localparam int S_ONLINE = 2;
  localparam int S_FAULT  = 3;
  localparam int S_DONE   = 4;
  localparam int S_TOUT   = 5;
  localparam int S_OVR    = 6;
  localparam int S_ACTIVE = 7;

  localparam int C_FEED  = 0;
  localparam int C_CHOOSE = 1;
  localparam int C_RESET = 2;
endpackage

// File: rtl/lpt_sync.sv
module lpt_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/lpt_pulse.sv
module lpt_pulse #(
  parameter int CYC = 501
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic active
);
  localparam int CW = $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end else if (start) begin
      cnt_en = 1'b1;
      cnt_d  = CW'(CYC);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/lpt_xfer.sv
module lpt_xfer
  import lpt_pkg::*;
#(
  parameter int STB_CYC   = 5,
  parameter int TLIM_W    = 8,
  parameter int TICK_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              hold_off,
  input  logic              busy_s,
  input  logic              ack_fall,
  input  logic [TLIM_W-1:0] tlim,
  output logic              stb_n,
  output logic              active,
  output logic              done_p,
  output logic              tout_p
);
  localparam int SW = $clog2(STB_CYC + 1);
  localparam int TW = TLIM_W + TICK_LOG2 + 1;

  xfer_st_e      st_q, st_d;
  logic [SW-1:0] scnt_q, scnt_d;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic [TW-1:0] tlimit;
  logic          to_hit;

  assign tlimit = {1'b0, tlim, {TICK_LOG2{1'b0}}};
  assign to_hit = (tlim != '0) && (tcnt_q >= tlimit);

  always_comb begin
    st_d   = st_q;
    scnt_d = scnt_q;
    tcnt_d = tcnt_q;
    done_p = 1'b0;
    tout_p = 1'b0;
    if (st_q != X_IDLE && tcnt_q != '1) tcnt_d = tcnt_q + 1'b1;
    unique case (st_q)
      X_IDLE: begin
        if (go) begin
          st_d   = X_WAITRDY;
          tcnt_d = '0;
        end
      end
      X_WAITRDY: begin
        if (!busy_s && !hold_off) begin
          st_d = X_SETUP;
        end else if (to_hit) begin
          st_d   = X_IDLE;
          tout_p = 1'b1;
        end
      end
      X_SETUP: begin
        st_d   = X_STROBE;
        scnt_d = SW'(STB_CYC - 1);
      end
      X_STROBE: begin
        if (scnt_q == '0) st_d = X_HOLD;
        else              scnt_d = scnt_q - 1'b1;
      end
      X_HOLD: st_d = X_WAITACK;
      X_WAITACK: begin
        if (ack_fall) begin
          st_d   = X_IDLE;
          done_p = 1'b1;
        end else if (to_hit) begin
          st_d   = X_IDLE;
          tout_p = 1'b1;
        end
      end
      default: st_d = X_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= X_IDLE;
      scnt_q <= '0;
      tcnt_q <= '0;
    end else begin
      st_q   <= st_d;
      scnt_q <= scnt_d;
      tcnt_q <= tcnt_d;
    end
  end

  assign stb_n  = (st_q != X_STROBE);
  assign active = (st_q != X_IDLE);
endmodule

// File: rtl/lpt_host_ctrl.sv
module lpt_host_ctrl
  import lpt_pkg::*;
#(
  parameter int CLK_KHZ   = 100000,
  parameter int STB_NS    = 500,
  parameter int INIT_US   = 50,
  parameter int TICK_LOG2 = 4,
  parameter int DW        = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic [DW-1:0] pr_data,
  output logic          pr_stb_n,
  output logic          pr_feed_n,
  output logic          pr_reset_n,
  output logic          pr_choose_n,
  input  logic          pr_busy,
  input  logic          pr_ack_n,
  input  logic          pr_nopaper,
  input  logic          pr_online,
  input  logic          pr_fault_n
);
  localparam int STB_CYC  = (CLK_KHZ * STB_NS + 999_999) / 1_000_000;
  localparam int INIT_CYC = (CLK_KHZ * INIT_US) / 1000 + 1;
  localparam int NIN      = 5;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sh_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_int_n = rst_sh_q[1];

  // input synchronizers: {fault_n, online, nopaper, ack_n, busy}
  logic [NIN-1:0] in_raw, in_s;
  logic busy_s, ack_s, nopap_s, online_s, fault_s_n;

  assign in_raw = {pr_fault_n, pr_online, pr_nopaper, pr_ack_n, pr_busy};

  lpt_sync #(.W(NIN), .RST_VAL(5'b10010)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d(in_raw), .q(in_s)
  );

  assign busy_s    = in_s[0];
  assign ack_s     = in_s[1];
  assign nopap_s   = in_s[2];
  assign online_s  = in_s[3];
  assign fault_s_n = in_s[4];

  logic ack_prev_q, ack_fall;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) ack_prev_q <= 1'b1;
    else            ack_prev_q <= ack_s;
  end
  assign ack_fall = ack_prev_q & ~ack_s;

  // register decode
  logic wr_data, wr_ctrl, wr_stat, wr_tlim;
  assign wr_data = reg_wr && (reg_addr == A_DATA);
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign wr_tlim = reg_wr && (reg_addr == A_TLIM);

  logic          xfer_active, done_p, tout_p, init_act, go;
  logic [DW-1:0] data_q;
  logic          feed_q, choose_q;
  logic [DW-1:0] tlim_q;
  logic          done_q, tout_q, ovr_q;
  logic          done_d, tout_d, ovr_d;

  assign go = wr_data && !xfer_active;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) data_q <= '0;
    else if (go)    data_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      feed_q   <= 1'b0;
      choose_q <= 1'b0;
    end else if (wr_ctrl) begin
      feed_q   <= reg_wdata[C_FEED];
      choose_q <= reg_wdata[C_CHOOSE];
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   tlim_q <= '0;
    else if (wr_tlim) tlim_q <= reg_wdata;
  end

  // sticky flags: set wins over write-one-to-clear
  always_comb begin
    done_d = done_q;
    tout_d = tout_q;
    ovr_d  = ovr_q;
    if (wr_stat) begin
      if (reg_wdata[S_DONE]) done_d = 1'b0;
      if (reg_wdata[S_TOUT]) tout_d = 1'b0;
      if (reg_wdata[S_OVR])  ovr_d  = 1'b0;
    end
    if (done_p)                     done_d = 1'b1;
    if (tout_p)                     tout_d = 1'b1;
    if (wr_data && xfer_active)     ovr_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      done_q <= 1'b0;
      tout_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      tout_q <= tout_d;
      ovr_q  <= ovr_d;
    end
  end

  lpt_xfer #(.STB_CYC(STB_CYC), .TLIM_W(DW), .TICK_LOG2(TICK_LOG2)) u_xfer (
    .clk(clk), .rst_n(rst_int_n), .go(go), .hold_off(init_act),
    .busy_s(busy_s), .ack_fall(ack_fall), .tlim(tlim_q),
    .stb_n(pr_stb_n), .active(xfer_active), .done_p(done_p), .tout_p(tout_p)
  );

  lpt_pulse #(.CYC(INIT_CYC)) u_init (
    .clk(clk), .rst_n(rst_int_n),
    .start(wr_ctrl && reg_wdata[C_RESET]), .active(init_act)
  );

  logic [7:0] stat_v;
  always_comb begin
    stat_v           = '0;
    stat_v[S_BUSY]   = busy_s;
    stat_v[S_NOPAP]  = nopap_s;
    stat_v[S_ONLINE] = online_s;
    stat_v[S_FAULT]  = ~fault_s_n;
    stat_v[S_DONE]   = done_q;
    stat_v[S_TOUT]   = tout_q;
    stat_v[S_OVR]    = ovr_q;
    stat_v[S_ACTIVE] = xfer_active;
  end

  always_comb begin
    unique case (reg_addr)
      A_DATA:  reg_rdata = data_q;
      A_CTRL:  reg_rdata = DW'({init_act, choose_q, feed_q});
      A_STAT:  reg_rdata = DW'(stat_v);
      default: reg_rdata = tlim_q;
    endcase
  end

  assign pr_data     = data_q;
  assign pr_feed_n   = ~feed_q;
  assign pr_choose_n = ~choose_q;
  assign pr_reset_n  = ~init_act;

  // ---------------- assertions ----------------
  localparam int SCW = $clog2(STB_CYC + 2);
  localparam int ICW = $clog2(INIT_CYC + 2);
  logic [SCW-1:0] chk_stb_len;
  logic [ICW-1:0] chk_init_len;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      chk_stb_len  <= '0;
      chk_init_len <= '0;
    end else begin
      chk_stb_len  <= pr_stb_n   ? '0 : chk_stb_len + 1'b1;
      chk_init_len <= pr_reset_n ? '0 : chk_init_len + 1'b1;
    end
  end

  a_r2_data_steady: assert property (@(posedge clk) disable iff (!rst_int_n)
    !pr_stb_n |-> $stable(pr_data));
  a_r2_data_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(pr_stb_n) |=> $stable(pr_data));
  a_r3_strobe_width: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(pr_stb_n) |-> (chk_stb_len == SCW'(STB_CYC)));
  a_r4_no_strobe_busy: assert property (@(posedge clk) disable iff (!rst_int_n)
    $fell(pr_stb_n) |-> (!$past(busy_s, 2) && !$past(init_act, 2)));
  a_r5_done_from_ack: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(done_q) |-> $past(ack_fall));
  a_r6_tout_idle: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(tout_q) |-> !xfer_active);
  a_r7_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_int_n)
    (wr_data && xfer_active) |=> ($stable(pr_data) && ovr_q));
  a_r8_init_width: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(pr_reset_n) |-> (chk_init_len == ICW'(INIT_CYC)));
endmodule

// File: tb/tb_lpt_host_ctrl.sv
`timescale 1ns/1ps
module tb_lpt_host_ctrl;
  localparam int CLK_KHZ  = 10000;
  localparam int STB_EXP  = (CLK_KHZ * 500 + 999_999) / 1_000_000;
  localparam int INIT_EXP = CLK_KHZ * 50 / 1000 + 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata, pr_data;
  logic       pr_stb_n, pr_feed_n, pr_reset_n, pr_choose_n;
  logic       pr_busy = 1'b0, pr_ack_n = 1'b1, pr_nopaper = 1'b0;
  logic       pr_online = 1'b0, pr_fault_n = 1'b1;

  lpt_host_ctrl #(.CLK_KHZ(CLK_KHZ), .STB_NS(500), .INIT_US(50), .TICK_LOG2(4)) dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pr_data(pr_data),
    .pr_stb_n(pr_stb_n), .pr_feed_n(pr_feed_n), .pr_reset_n(pr_reset_n),
    .pr_choose_n(pr_choose_n), .pr_busy(pr_busy), .pr_ack_n(pr_ack_n),
    .pr_nopaper(pr_nopaper), .pr_online(pr_online), .pr_fault_n(pr_fault_n)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done_run = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // monitors (observe outputs only)
  bit prev_stb = 1, prev_rst = 1;
  logic [7:0] prev_pd = '0, cap_pd = '0;
  int stb_falls = 0, low_len = 0, last_w = 0, fall_cyc = 0;
  bit setup_ok = 0, steady_ok = 0, hold_ok = 0;
  int init_len = 0, last_init_w = 0, init_rise_cyc = 0;

  initial forever begin
    @(negedge clk);
    cyc++;
    if (!pr_stb_n) begin
      if (prev_stb) begin
        stb_falls++; fall_cyc = cyc; setup_ok = (pr_data == prev_pd);
        cap_pd = pr_data; low_len = 1; steady_ok = 1;
      end else begin
        low_len++;
        if (pr_data != cap_pd) steady_ok = 0;
      end
    end else if (!prev_stb) begin
      last_w = low_len; hold_ok = (pr_data == cap_pd);
    end
    if (!pr_reset_n) init_len++;
    else if (!prev_rst) begin last_init_w = init_len; init_len = 0; init_rise_cyc = cyc; end
    prev_stb = pr_stb_n; prev_rst = pr_reset_n; prev_pd = pr_data;
  end

  // printer model
  bit auto_resp = 0;
  initial forever begin
    @(negedge clk);
    if (auto_resp && !pr_stb_n) begin
      pr_busy = 1'b1;
      while (!pr_stb_n) @(negedge clk);
      repeat (2) @(negedge clk);
      pr_ack_n = 1'b0;
      repeat (4) @(negedge clk);
      pr_ack_n = 1'b1;
      pr_busy = 1'b0;
    end
  end

  task automatic wait_idle(input int lim);
    logic [7:0] s;
    for (int i = 0; i < lim; i++) begin
      rd(2'd2, s);
      if (!s[7]) break;
    end
  endtask

  task automatic manual_ack;
    @(negedge clk); pr_ack_n = 1'b0;
    repeat (4) @(negedge clk); pr_ack_n = 1'b1;
  endtask

  initial begin
    logic [7:0] v;
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(pr_stb_n && pr_feed_n && pr_choose_n && pr_reset_n, "R1 lines high", 0, 1);
    chk(pr_data == 8'h00, "R1 data zero", pr_data, 0);
    rd(2'd2, v); chk(v == 8'h00, "R1 status", v, 0);
    rd(2'd1, v); chk(v == 8'h00, "R1 control", v, 0);

    // R9 control lines
    for (int c = 0; c < 4; c++) begin
      wr(2'd1, 8'(c));
      @(negedge clk);
      chk(pr_feed_n == !c[0], "R9 feed", pr_feed_n, !c[0]);
      chk(pr_choose_n == !c[1], "R9 choose", pr_choose_n, !c[1]);
      rd(2'd1, v); chk(v == 8'(c), "R9 readback", v, c);
    end
    wr(2'd1, 8'h00);

    // R10 status input mapping
    for (int p = 0; p < 16; p++) begin
      @(negedge clk);
      pr_busy = p[0]; pr_nopaper = p[1]; pr_online = p[2]; pr_fault_n = !p[3];
      repeat (3) @(negedge clk);
      rd(2'd2, v); chk(v[3:0] == 4'(p), "R10 status inputs", v[3:0], p);
    end
    @(negedge clk);
    pr_busy = 0; pr_nopaper = 0; pr_online = 0; pr_fault_n = 1;
    repeat (3) @(negedge clk);

    // R2 R3 R5 sweep of every byte
    auto_resp = 1;
    for (int b = 0; b < 256; b++) begin
      f0 = stb_falls;
      wr(2'd0, 8'(b));
      wait_idle(200);
      chk(stb_falls == f0 + 1, "R2 one strobe", stb_falls - f0, 1);
      chk(cap_pd == 8'(b) && setup_ok && steady_ok && hold_ok, "R2 data window", cap_pd, b);
      chk(last_w == STB_EXP, "R3 strobe width", last_w, STB_EXP);
      rd(2'd2, v); chk(v[4] && !v[5] && !v[7], "R5 done", v, 8'h10);
      wr(2'd2, 8'h10);
      rd(2'd2, v); chk(!v[4], "R10 done clear", v[4], 0);
      repeat (6) @(negedge clk);
    end

    // R4 busy blocks strobe, R7 overrun
    auto_resp = 0;
    @(negedge clk); pr_busy = 1'b1;
    repeat (3) @(negedge clk);
    f0 = stb_falls;
    wr(2'd0, 8'hA5);
    repeat (40) @(negedge clk);
    chk(stb_falls == f0, "R4 no strobe while busy", stb_falls - f0, 0);
    wr(2'd0, 8'h3C);
    @(negedge clk);
    chk(pr_data == 8'hA5, "R7 data kept", pr_data, 8'hA5);
    rd(2'd2, v); chk(v[6], "R7 overrun bit", v[6], 1);
    pr_busy = 1'b0;
    repeat (20) @(negedge clk);
    chk(stb_falls == f0 + 1, "R4 strobe after release", stb_falls - f0, 1);
    manual_ack;
    wait_idle(50);
    rd(2'd2, v); chk(v[4] && v[6], "R5 done after release", v, 8'h50);
    wr(2'd2, 8'h70);
    rd(2'd2, v); chk(v[6:4] == 3'b000, "R10 w1c flags", v[6:4], 0);

    // R6 timeout with L=4 (64 clocks)
    wr(2'd3, 8'd4);
    wr(2'd0, 8'h11);
    repeat (50) @(negedge clk);
    rd(2'd2, v); chk(v[7] && !v[5], "R6 still active before limit", v, 8'h80);
    repeat (25) @(negedge clk);
    rd(2'd2, v); chk(!v[7] && v[5] && !v[4], "R6 timed out", v, 8'h20);
    wr(2'd2, 8'h20);
    // L=0 disables
    wr(2'd3, 8'd0);
    wr(2'd0, 8'h22);
    repeat (300) @(negedge clk);
    rd(2'd2, v); chk(v[7] && !v[5], "R6 disabled no timeout", v, 8'h80);
    manual_ack;
    wait_idle(50);
    rd(2'd2, v); chk(v[4] && !v[7], "R6 ack ends open transfer", v, 8'h10);
    wr(2'd2, 8'h10);

    // R8 reset pulse, retrigger ignored, strobe held off
    auto_resp = 1;
    wr(2'd1, 8'h04);
    repeat (5) @(negedge clk);
    rd(2'd1, v); chk(v[2], "R8 control bit2 active", v[2], 1);
    f0 = stb_falls;
    wr(2'd0, 8'h5A);
    repeat (100) @(negedge clk);
    wr(2'd1, 8'h04);
    while (!pr_reset_n) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(last_init_w == INIT_EXP, "R8 reset width", last_init_w, INIT_EXP);
    wait_idle(100);
    chk(stb_falls == f0 + 1 && fall_cyc > init_rise_cyc, "R4 strobe after reset pulse",
        fall_cyc - init_rise_cyc, 1);
    chk(cap_pd == 8'h5A, "R2 byte after reset pulse", cap_pd, 8'h5A);
    rd(2'd1, v); chk(!v[2], "R8 control bit2 clears", v[2], 0);

    done_run = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_run) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule